// File: doc/BRIEF.md
# Baseline Four-Instruction Microcontroller Core

This block is a small two-stage core for 12-bit instruction words. It fetches one word per cycle from a synchronous program memory and executes the previously fetched word in the same cycle. Because fetch and execute overlap, a taken jump or skip discards the word that is already in flight, and a dead cycle follows.

The core executes four operations:

- **Complement**: write the bitwise inverse of a register.
- **Decrement**: write the register value minus one.
- **Decrement-and-skip-on-zero**: write the register value minus one and skip the next word when the result is zero.
- **Paged jump**.

Every other opcode retires as a no-operation. Operands come from a 32-entry file of 8-bit registers. A destination bit sends the result either to the accumulator W or back to the file. Address 3 of the file is the status register, and writing it sets the page bits that the jump uses for the top of the program counter.

Debug outputs expose W, the status register and the current fetch address. A one-cycle retire pulse marks the cycle in which the effects of one executed instruction first show on those outputs, so an external model can follow the core instruction by instruction.

Top module: `subset_core`

## Requirements
- R1: Reset clears W, the status register, all 32 file registers and the fetch address to zero. The first cycle after reset is a bubble with no retire pulse, and the word at address 0 is the first to execute.
- R2: Opcode 0010_01d_fffff (bits 11:6 = 001001, d = bit 5, f = bits 4:0) writes the inverse of register f and sets status bit 2 (Z) to 1 when the 8-bit result is 0, else to 0.
- R3: Opcode 0000_11d_fffff writes register f minus 1, modulo 256, and updates Z the same way.
- R4: Opcode 0010_11d_fffff writes register f minus 1 and changes no status bit. When the result is 0, the next word is discarded and a dead cycle follows; otherwise it takes one cycle.
- R5: For the three register operations, d = 0 writes the result to W and leaves the file unchanged; d = 1 writes it back to register f and leaves W unchanged.
- R6: Opcode 101k_kkkk_kkkk loads the 9-bit k into fetch address bits 8:0 and status bits 6:5 into address bits 10:9. The prefetched word is discarded and a dead cycle follows.
- R7: Any other opcode retires with W, status and file unchanged, and the fetch address advances by one.
- R8: Apart from jumps, the fetch address advances by one each cycle and wraps from 0x7FF to 0x000.
- R9: File address 3 reads and writes the status register. For complement and decrement with d = 1 at address 3, the written value lands with bit 2 replaced by the new Z. For decrement-and-skip, the full value lands.
- R10: The retire output pulses exactly once per executed instruction. While it is high, W, status and the fetch address show that instruction's results. Pulses are one cycle apart, or two cycles apart after a discard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 11 | Program memory fetch address |
| imem_data | input | 12 | Word returned by program memory one cycle after its address |
| dbg_w | output | 8 | Accumulator W |
| dbg_status | output | 8 | Status register (bit 2 is Z, bits 6:5 are the page bits) |
| dbg_pc | output | 11 | Current fetch address |
| dbg_retire | output | 1 | One-cycle pulse per executed instruction |

## Verification
The assertions take the following for granted:

- The program memory returns a defined 12-bit word exactly one cycle after each address.
- Reset is held low from time zero until at least one edge has passed.

They inspect the incoming word only in cycles the core marks as executing, so values on the data pins during bubbles do not matter. The stimulus meets these conditions by modelling the memory as a registered array that is loaded in full while reset is held, with every unwritten location left at zero. Test programs that set the page bits through the status alias drive jumps into the upper pages and across the address wrap.

// File: rtl/subset_core.sv
module subset_core #(
  parameter int STATUS_ADDR = 3,
  parameter int Z_BIT       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [10:0] imem_addr,
  input  logic [11:0] imem_data,
  output logic [7:0]  dbg_w,
  output logic [7:0]  dbg_status,
  output logic [10:0] dbg_pc,
  output logic        dbg_retire
);
  localparam int NREGS = 32;

  logic [7:0]  regs [NREGS];
  logic [7:0]  w, status, status_nx;
  logic [10:0] pc;
  logic        exec_valid, retire;

  logic [4:0] fa;
  logic       dst_file;
  logic       is_comf, is_decf, is_dsz, is_goto, alu_op, at_status;
  logic [7:0] operand, res;
  logic       res_zero, take_skip;

  assign fa        = imem_data[4:0];
  assign dst_file  = imem_data[5];
  assign is_comf   = exec_valid && imem_data[11:6] == 6'b001001;
  assign is_decf   = exec_valid && imem_data[11:6] == 6'b000011;
  assign is_dsz    = exec_valid && imem_data[11:6] == 6'b001011;
  assign is_goto   = exec_valid && imem_data[11:9] == 3'b101;
  assign alu_op    = is_comf || is_decf || is_dsz;
  assign at_status = fa == 5'(STATUS_ADDR);

  assign operand   = at_status ? status : regs[fa];
  assign res       = is_comf ? ~operand : operand - 8'd1;
  assign res_zero  = res == 8'd0;
  assign take_skip = is_dsz && res_zero;

  always_comb begin
    status_nx = status;
    if (alu_op && dst_file && at_status) status_nx = res;
    if (is_comf || is_decf) status_nx[Z_BIT] = res_zero;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w          <= '0;
      status     <= '0;
      pc         <= '0;
      exec_valid <= 1'b0;
      retire     <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      retire     <= exec_valid;
      exec_valid <= !(is_goto || take_skip);
      pc         <= is_goto ? {status[6:5], imem_data[8:0]} : pc + 11'd1;
      status     <= status_nx;
      if (alu_op && !dst_file) w <= res;
      if (alu_op && dst_file && !at_status) regs[fa] <= res;
    end
  end

  assign imem_addr  = pc;
  assign dbg_pc     = pc;
  assign dbg_w      = w;
  assign dbg_status = status;
  assign dbg_retire = retire;
endmodule

// File: rtl/subset_core_chk.sv
module subset_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_valid,
  input logic [11:0] instr,
  input logic [10:0] pc,
  input logic [7:0]  w,
  input logic [7:0]  status
);
  logic c_comf, c_decf, c_dsz, c_goto, c_other;
  assign c_comf  = exec_valid && instr[11:6] == 6'b001001;
  assign c_decf  = exec_valid && instr[11:6] == 6'b000011;
  assign c_dsz   = exec_valid && instr[11:6] == 6'b001011;
  assign c_goto  = exec_valid && instr[11:9] == 3'b101;
  assign c_other = exec_valid && !(c_comf || c_decf || c_dsz || c_goto);

  assert_goto_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_goto |=> pc == {$past(status[6:5]), $past(instr[8:0])});

  assert_goto_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_goto |=> !exec_valid);

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !c_goto |=> pc == $past(pc) + 11'd1);

  assert_skip_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dsz && (!instr[5] || instr[4:0] != 5'd3)) |=> $stable(status));

  assert_other_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    c_other |=> $stable(w) && $stable(status));

  assert_file_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_comf || c_decf || c_dsz) && instr[5]) |=> $stable(w));

  // also covers R2
  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_comf || c_decf) && !instr[5]) |=> status[2] == (w == 8'd0));
endmodule

bind subset_core subset_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .instr(imem_data),
  .pc(pc), .w(w), .status(status)
);

// File: tb/tb_subset_core.sv
`timescale 1ns/1ps
module tb_subset_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] imem_addr;
  logic [11:0] imem_data = '0;
  logic [7:0]  dbg_w, dbg_status;
  logic [10:0] dbg_pc;
  logic        dbg_retire;

  always #10 clk = ~clk;

  subset_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dbg_w(dbg_w), .dbg_status(dbg_status), .dbg_pc(dbg_pc), .dbg_retire(dbg_retire)
  );

  logic [11:0] prog [2048];
  always @(posedge clk) imem_data <= prog[imem_addr];

  typedef struct {
    logic [7:0]  w;
    logic [7:0]  st;
    logic [10:0] pc;
    int          gap;
    int          kind;
    int          step;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0;
  bit armed = 0;
  int gap = 0;

  function automatic string tag_of(int kind);
    case (kind)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      8: return "R8";
      9: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [11:0] op_comf(int f, int d);   return {6'b001001, 1'(d), 5'(f)}; endfunction
  function automatic logic [11:0] op_decf(int f, int d);   return {6'b000011, 1'(d), 5'(f)}; endfunction
  function automatic logic [11:0] op_dsz(int f, int d);    return {6'b001011, 1'(d), 5'(f)}; endfunction
  function automatic logic [11:0] op_goto(int k);          return {3'b101, 9'(k)}; endfunction

  task automatic clear_prog();
    for (int i = 0; i < 2048; i++) prog[i] = 12'h000;
  endtask

  // reference model of the four operations
  task automatic build_expect(input int nsteps);
    logic [7:0]  m_w = 0, m_st = 0, op, res;
    logic [7:0]  m_f [32];
    logic [10:0] m_pc = 0, npc;
    logic [11:0] ins;
    int gnext = 2;
    for (int i = 0; i < 32; i++) m_f[i] = 0;
    for (int s = 0; s < nsteps; s++) begin
      item_t it;
      logic [4:0] fa;
      logic d, flush, alu, zupd;
      int kind;
      ins = prog[m_pc];
      fa = ins[4:0]; d = ins[5];
      op = (fa == 5'd3) ? m_st : m_f[fa];
      flush = 0; alu = 1; zupd = 0; kind = 7; res = 0;
      npc = m_pc + 11'd1;
      if (ins[11:6] == 6'b001001) begin res = ~op; zupd = 1; kind = 2; end
      else if (ins[11:6] == 6'b000011) begin res = op - 8'd1; zupd = 1; kind = 3; end
      else if (ins[11:6] == 6'b001011) begin res = op - 8'd1; kind = 4; end
      else begin
        alu = 0;
        if (ins[11:9] == 3'b101) begin
          npc = {m_st[6:5], ins[8:0]}; flush = 1; kind = 6;
        end
      end
      if (alu) begin
        if (d) begin
          if (fa == 5'd3) m_st = res; else m_f[fa] = res;
        end else m_w = res;
        if (zupd) m_st[2] = (res == 8'd0);
        if (kind == 4 && res == 8'd0) begin flush = 1; npc = m_pc + 11'd2; end
        if (fa == 5'd3 && d) kind = 9;
        else if (!d && kind != 4) kind = 5;
      end
      if (m_pc >= 11'h7FE) kind = 8;
      it.w = m_w; it.st = m_st;
      it.pc = (ins[11:9] == 3'b101 && !alu) ? npc : m_pc + 11'd2;
      it.gap = gnext; it.kind = kind; it.step = s;
      q.push_back(it);
      gnext = flush ? 2 : 1;
      m_pc = npc;
    end
  endtask

  // monitor: pops expected items on each retire pulse
  always @(negedge clk) begin
    if (!rst_n) gap = 0;
    else begin
      gap++;
      if (dbg_retire && armed) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (dbg_w !== e.w || dbg_status !== e.st || dbg_pc !== e.pc) begin
          errors++;
          $display("FAIL %s step %0d: w=%h exp %h st=%h exp %h pc=%h exp %h",
                   tag_of(e.kind), e.step, dbg_w, e.w, dbg_status, e.st, dbg_pc, e.pc);
        end
        checks++;
        if (gap != e.gap) begin
          errors++;
          $display("FAIL R10 step %0d: retire spacing %0d exp %0d", e.step, gap, e.gap);
        end
        gap = 0;
        if (q.size() == 0) armed = 0;
      end
    end
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic run_test(input int nsteps);
    @(negedge clk); #2 rst_n = 0;
    repeat (3) @(negedge clk);
    check(dbg_w == 0 && dbg_status == 0 && dbg_pc == 0 && dbg_retire == 0,
          $sformatf("R1 reset: w=%h st=%h pc=%h ret=%b exp 00 00 000 0", dbg_w, dbg_status, dbg_pc, dbg_retire));
    build_expect(nsteps);
    armed = 1;
    #2 rst_n = 1;
    @(negedge clk);
    check(dbg_retire == 0 && dbg_pc == 11'd1,
          $sformatf("R1 bubble: ret=%b pc=%h exp 0 001", dbg_retire, dbg_pc));
    while (armed) @(negedge clk);
  endtask

  initial begin
    // T1: complement/decrement, both destinations, Z (R2 R3 R5)
    clear_prog();
    prog[0] = op_decf(8, 1);  prog[1] = op_comf(8, 0);  prog[2] = op_decf(8, 0);
    prog[3] = op_comf(9, 1);  prog[4] = op_decf(9, 0);  prog[5] = op_comf(8, 1);
    prog[6] = op_decf(8, 0);  prog[7] = op_comf(10, 0); prog[8] = op_goto(8);
    run_test(12);

    // T2: decrement-and-skip with and without skip (R4)
    clear_prog();
    prog[0] = op_decf(12, 1); prog[1] = op_decf(12, 1); prog[2] = op_comf(12, 1);
    prog[3] = op_dsz(12, 0);  prog[4] = op_comf(12, 0); prog[5] = op_dsz(12, 1);
    prog[6] = op_comf(12, 0); prog[7] = op_dsz(16, 0);  prog[8] = op_dsz(12, 0);
    prog[9] = op_comf(17, 0); prog[10] = op_decf(17, 0); prog[11] = op_dsz(17, 0);
    prog[12] = op_goto(12);
    run_test(16);

    // T3: status alias, page bits, paged jumps, unknown opcode (R6 R7 R9)
    clear_prog();
    prog[0] = op_comf(3, 1);  prog[1] = op_goto(5);
    prog[11'h605] = op_decf(3, 1); prog[11'h606] = op_dsz(3, 1);
    prog[11'h607] = op_goto(9'h010);
    prog[11'h610] = op_comf(3, 1); prog[11'h611] = op_goto(9'h020);
    prog[11'h020] = 12'hFFF; prog[11'h021] = 12'h7A5;
    prog[11'h022] = op_comf(3, 0); prog[11'h023] = op_goto(9'h023);
    run_test(14);

    // T4: address wrap from top page (R8)
    clear_prog();
    prog[0] = op_comf(3, 1); prog[1] = op_goto(9'h1FE);
    prog[11'h7FE] = 12'h0A5; prog[11'h7FF] = op_decf(20, 1);
    prog[11'h1FE] = op_goto(9'h1FE);
    run_test(10);

    // T5: counted loop of 255 passes (R4 R10)
    clear_prog();
    prog[0] = op_comf(21, 1); prog[1] = op_dsz(21, 1); prog[2] = op_goto(1);
    prog[3] = op_comf(21, 0); prog[4] = op_goto(4);
    run_test(516);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired, expected items left %0d", q.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule